// File: doc/BRIEF.md
# Data Cache with Line Zero and Line Discard Commands

A small direct-mapped, write-back, write-allocate data cache that sits between a processor load/store port and a line-wide memory port. Beside ordinary loads and stores, the processor can send two line maintenance commands. The first claims the addressed line and fills it with zeros without reading memory. It is meant for clearing large regions, or for claiming fresh stack frames, with no fetch traffic. The second drops the addressed line without writing it back, even when it holds modified data. It is meant for discarding released stack space that must never reach memory.

Both maintenance commands act on whole lines, so clearing a region takes one command per line. Line size is a parameter (64 or 128 bytes) and the number of sets is a parameter. The only gate on the maintenance commands is a privilege flag that comes with each request. No lock or protection attribute of the target line is consulted. An unprivileged maintenance request is refused with a one-cycle fault and leaves the cache untouched.

The processor side uses a ready/valid handshake. A request is taken only while `req_ready` is high. Every request produces exactly one `rsp_valid` pulse. The memory side issues one line read or one line write at a time. Each transfer is held until memory acknowledges it.

Top module: `dcache_lineops`

## Requirements
- R1: A load (command code 0) that hits returns the addressed word on `rsp_rdata` with `rsp_valid` high in the cycle after acceptance, with no memory transfer.
- R2: A store (command code 1) writes only the bytes whose `req_be` bit is set and marks the line modified, so a later load sees the merged word and a later eviction writes the merged line to memory.
- R3: A load or store that misses in its set (set index = address bits [7:6] for the default 64-byte lines and 4 sets; tag = the bits above) first writes back the resident line if it is valid and modified, then reads the new line from memory, then completes the access. A clean or empty set gets only the read.
- R4: A privileged line-zero command (command code 2) leaves the addressed line resident with every byte zero, and never issues a memory read.
- R5: When a line-zero command finds a valid, modified line with a different tag in its set, that line is written back before the set is reused. No memory read follows.
- R6: A line set by a line-zero command is valid and modified, so its zeros reach memory when it is later evicted.
- R7: A privileged line-discard command (command code 3) that hits makes the line invalid without any memory write, even if it is modified. The next access to that address reads the old memory contents.
- R8: A line-discard command that misses responds in the cycle after acceptance with no memory transfer.
- R9: A maintenance command (code 2 or 3) with `req_priv` low (1 = privileged) is refused. `fault` and `rsp_valid` are high together for exactly one cycle, the cache contents are unchanged, and there is no memory transfer.
- R10: `req_ready` is high only when the cache is idle, and is low for as long as any memory transfer is outstanding.
- R11: A memory request keeps `mem_req`, `mem_we` and a line-aligned `mem_addr` stable until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_cmd | input | 2 | 0 load, 1 store, 2 line zero, 3 line discard |
| req_addr | input | ADDR_W | Word-aligned byte address |
| req_wdata | input | WORD_W | Store data |
| req_be | input | WORD_W/8 | Store byte enables |
| req_priv | input | 1 | Requester is privileged |
| req_ready | output | 1 | Cache idle and able to take a request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | WORD_W | Load data, valid with a load completion |
| fault | output | 1 | Maintenance command refused |
| mem_req | output | 1 | Memory transfer outstanding |
| mem_we | output | 1 | Transfer is a line write-back |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | LINE_BYTES*8 | Line being written back |
| mem_rdata | input | LINE_BYTES*8 | Refill line, sampled with mem_ack |
| mem_ack | input | 1 | Memory completes the transfer this cycle |

## Verification
The embedded properties take for granted that requests arrive word-aligned and only while `req_ready` is high. They also assume memory answers each transfer with a single-cycle `mem_ack` that is raised only while `mem_req` is high. The stimulus keeps within these limits: it issues one request at a time from an idle cache, draws only aligned addresses from a 4 KB window so that tags collide often, and uses a bench memory that acknowledges once per transfer after a latency of zero to three cycles. Against this traffic, a behavioural model of the tag, dirty and line state predicts each response, its timing and the exact number of memory reads and write-backs.

// File: rtl/dc_pkg.sv
`timescale 1ns/1ps
package dc_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_ZERO  = 2'd2,
      OP_INVAL = 2'd3
   } dc_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_EVICT,
      ST_REFILL,
      ST_FINISH
   } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
`timescale 1ns/1ps
module dc_tag_store #(
   parameter int SETS  = 4,
   parameter int TAG_W = 24
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(SETS)-1:0]  idx,
   input  logic                     we,
   input  logic                     wvalid,
   input  logic                     wdirty,
   input  logic [TAG_W-1:0]         wtag,
   output logic                     rvalid,
   output logic                     rdirty,
   output logic [TAG_W-1:0]         rtag
);
   logic [SETS-1:0]  valid_q;
   logic [SETS-1:0]  dirty_q;
   logic [TAG_W-1:0] tag_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (we) begin
         valid_q[idx] <= wvalid;
         dirty_q[idx] <= wdirty;
      end
   end

   always_ff @(posedge clk) begin
      if (we) tag_q[idx] <= wtag;
   end

   assign rvalid = valid_q[idx];
   assign rdirty = dirty_q[idx];
   assign rtag   = tag_q[idx];

   // a modified line must be resident (R6)
   for (genvar s = 0; s < SETS; s++) begin : g_chk
      p_dirty_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
         dirty_q[s] |-> valid_q[s]);
   end
endmodule

// File: rtl/dc_line_store.sv
`timescale 1ns/1ps
module dc_line_store #(
   parameter int SETS       = 4,
   parameter int LINE_BYTES = 64,
   parameter int WORD_W     = 32
) (
   input  logic                                     clk,
   input  logic [$clog2(SETS)-1:0]                  idx,
   input  logic [$clog2(LINE_BYTES*8/WORD_W)-1:0]   word_sel,
   input  logic                                     line_we,
   input  logic [LINE_BYTES*8-1:0]                  line_wdata,
   input  logic                                     word_we,
   input  logic [WORD_W/8-1:0]                      be,
   input  logic [WORD_W-1:0]                        wdata,
   output logic [LINE_BYTES*8-1:0]                  rd_line,
   output logic [WORD_W-1:0]                        rd_word
);
   localparam int LINE_W = LINE_BYTES * 8;
   localparam int WORDS  = LINE_W / WORD_W;
   localparam int WB     = WORD_W / 8;

   logic [LINE_W-1:0] line_q [SETS];
   logic [WORD_W-1:0] words  [WORDS];

   always_ff @(posedge clk) begin
      if (line_we) begin
         line_q[idx] <= line_wdata;
      end else if (word_we) begin
         for (int b = 0; b < WB; b++) begin
            if (be[b]) line_q[idx][int'(word_sel) * WORD_W + b * 8 +: 8] <= wdata[b*8 +: 8];
         end
      end
   end

   assign rd_line = line_q[idx];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign words[w] = rd_line[w*WORD_W +: WORD_W];
   end
   assign rd_word = words[word_sel];
endmodule

// File: rtl/dc_ctrl.sv
`timescale 1ns/1ps
module dc_ctrl
   import dc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int SETS       = 4,
   localparam int WB        = WORD_W / 8,
   localparam int WOFF_W    = $clog2(WB),
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int IDX_W     = $clog2(SETS),
   localparam int WSEL_W    = OFF_W - WOFF_W,
   localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
   localparam int LINE_W    = LINE_BYTES * 8,
   localparam int WA_W      = ADDR_W - WOFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   input  logic [WB-1:0]     req_be,
   input  logic              req_priv,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_rdata,
   output logic              fault,
   output logic [IDX_W-1:0]  set_idx,
   input  logic              t_valid,
   input  logic              t_dirty,
   input  logic [TAG_W-1:0]  t_tag,
   output logic              t_we,
   output logic              t_wvalid,
   output logic              t_wdirty,
   output logic [TAG_W-1:0]  t_wtag,
   output logic [WSEL_W-1:0] word_sel,
   input  logic [LINE_W-1:0] d_line,
   input  logic [WORD_W-1:0] d_word,
   output logic              d_line_we,
   output logic [LINE_W-1:0] d_line_wdata,
   output logic              d_word_we,
   output logic [WB-1:0]     d_be,
   output logic [WORD_W-1:0] d_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LINE_W-1:0] mem_wdata,
   input  logic [LINE_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   dc_state_e         state_q, state_d;
   dc_op_e            lat_op, cur_op;
   logic [WA_W-1:0]   lat_wa, cur_wa;
   logic [WORD_W-1:0] lat_wdata, rdata_q;
   logic [WB-1:0]     lat_be;
   logic [TAG_W-1:0]  cur_tag;
   logic idle, acc, hit, maint, deny, miss_mem, exec, fill_done, rsp_q, fault_q;

   assign idle     = (state_q == ST_IDLE);
   assign acc      = req_valid && idle;
   assign cur_op   = idle ? dc_op_e'(req_cmd) : lat_op;
   assign cur_wa   = idle ? req_addr[ADDR_W-1:WOFF_W] : lat_wa;
   assign d_wdata  = idle ? req_wdata : lat_wdata;
   assign d_be     = idle ? req_be : lat_be;
   assign cur_tag  = cur_wa[WA_W-1 -: TAG_W];
   assign set_idx  = cur_wa[WSEL_W +: IDX_W];
   assign word_sel = cur_wa[WSEL_W-1:0];

   assign hit       = t_valid && (t_tag == cur_tag);
   assign maint     = (cur_op == OP_ZERO) || (cur_op == OP_INVAL);
   assign deny      = acc && maint && !req_priv;
   assign miss_mem  = acc && !deny && !hit &&
                      ((cur_op == OP_LOAD) || (cur_op == OP_STORE) ||
                       ((cur_op == OP_ZERO) && t_valid && t_dirty));
   assign exec      = (acc && !deny && !miss_mem) || (state_q == ST_FINISH);
   assign fill_done = (state_q == ST_REFILL) && mem_ack;

   always_comb begin
      t_we      = 1'b0;
      t_wvalid  = 1'b0;
      t_wdirty  = 1'b0;
      t_wtag    = cur_tag;
      d_line_we = 1'b0;
      d_word_we = 1'b0;
      if (fill_done) begin
         t_we      = 1'b1;
         t_wvalid  = 1'b1;
         d_line_we = 1'b1;
      end else if (exec) begin
         case (cur_op)
            OP_STORE: begin t_we = 1'b1; t_wvalid = 1'b1; t_wdirty = 1'b1; d_word_we = 1'b1; end
            OP_ZERO:  begin t_we = 1'b1; t_wvalid = 1'b1; t_wdirty = 1'b1; d_line_we = 1'b1; end
            OP_INVAL: t_we = hit;
            default:  ;
         endcase
      end
   end
   assign d_line_wdata = fill_done ? mem_rdata : '0;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:   if (miss_mem) state_d = (t_valid && t_dirty) ? ST_EVICT : ST_REFILL;
         ST_EVICT:  if (mem_ack) state_d = (lat_op == OP_ZERO) ? ST_FINISH : ST_REFILL;
         ST_REFILL: if (mem_ack) state_d = ST_FINISH;
         default:   state_d = ST_IDLE;
      endcase
   end

   assign mem_req   = (state_q == ST_EVICT) || (state_q == ST_REFILL);
   assign mem_we    = (state_q == ST_EVICT);
   assign mem_addr  = {(mem_we ? t_tag : cur_tag), set_idx, {OFF_W{1'b0}}};
   assign mem_wdata = d_line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         lat_op    <= OP_LOAD;
         lat_wa    <= '0;
         lat_wdata <= '0;
         lat_be    <= '0;
         rsp_q     <= 1'b0;
         fault_q   <= 1'b0;
         rdata_q   <= '0;
      end else begin
         state_q <= state_d;
         if (acc) begin
            lat_op    <= cur_op;
            lat_wa    <= cur_wa;
            lat_wdata <= req_wdata;
            lat_be    <= req_be;
         end
         rsp_q   <= exec || deny;
         fault_q <= deny;
         if (exec && cur_op == OP_LOAD) rdata_q <= d_word;
      end
   end

   assign req_ready = idle;
   assign rsp_valid = rsp_q;
   assign fault     = fault_q;
   assign rsp_rdata = rdata_q;

   p_aligned_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_addr[WOFF_W-1:0] == '0));
   p_hit_load_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && hit && cur_op == OP_LOAD) |=> (rsp_valid && !fault && !mem_req));
   p_refill_then_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_REFILL) && mem_ack) |=> (!mem_req ##1 rsp_valid));
   p_no_read_for_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (lat_op == OP_LOAD || lat_op == OP_STORE));
   p_zero_evicts_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cur_op == OP_ZERO && req_priv && !hit && t_valid && t_dirty) |=> (mem_req && mem_we));
   p_discard_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cur_op == OP_INVAL) |=> (!mem_req && req_ready));
   p_discard_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cur_op == OP_INVAL && req_priv) |=> (rsp_valid && !fault));
   p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && maint && !req_priv) |=> (fault && rsp_valid && req_ready));
   p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: rtl/dcache_lineops.sv
`timescale 1ns/1ps
module dcache_lineops #(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int SETS       = 4,
   localparam int WB        = WORD_W / 8,
   localparam int LINE_W    = LINE_BYTES * 8,
   localparam int IDX_W     = $clog2(SETS),
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int WSEL_W    = OFF_W - $clog2(WB),
   localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   input  logic [WB-1:0]     req_be,
   input  logic              req_priv,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_rdata,
   output logic              fault,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LINE_W-1:0] mem_wdata,
   input  logic [LINE_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   if (LINE_BYTES != 64 && LINE_BYTES != 128) begin : g_bad_line
      $error("LINE_BYTES must be 64 or 128");
   end
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (WORD_W < 16 || (WORD_W % 8) != 0 || (1 << $clog2(WB)) != WB) begin : g_bad_word
      $error("WORD_W must be a power-of-two byte count of at least 16 bits");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for the chosen geometry");
   end

   logic [IDX_W-1:0]  set_idx;
   logic [WSEL_W-1:0] word_sel;
   logic              t_valid, t_dirty, t_we, t_wvalid, t_wdirty;
   logic [TAG_W-1:0]  t_tag, t_wtag;
   logic [LINE_W-1:0] d_line, d_line_wdata;
   logic [WORD_W-1:0] d_word, d_wdata;
   logic              d_line_we, d_word_we;
   logic [WB-1:0]     d_be;

   dc_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_be(req_be), .req_priv(req_priv), .req_ready(req_ready), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .fault(fault),
      .set_idx(set_idx), .t_valid(t_valid), .t_dirty(t_dirty), .t_tag(t_tag),
      .t_we(t_we), .t_wvalid(t_wvalid), .t_wdirty(t_wdirty), .t_wtag(t_wtag),
      .word_sel(word_sel), .d_line(d_line), .d_word(d_word), .d_line_we(d_line_we),
      .d_line_wdata(d_line_wdata), .d_word_we(d_word_we), .d_be(d_be), .d_wdata(d_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   dc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .idx(set_idx), .we(t_we), .wvalid(t_wvalid),
      .wdirty(t_wdirty), .wtag(t_wtag), .rvalid(t_valid), .rdirty(t_dirty), .rtag(t_tag)
   );

   dc_line_store #(.SETS(SETS), .LINE_BYTES(LINE_BYTES), .WORD_W(WORD_W)) u_lines (
      .clk(clk), .idx(set_idx), .word_sel(word_sel), .line_we(d_line_we),
      .line_wdata(d_line_wdata), .word_we(d_word_we), .be(d_be), .wdata(d_wdata),
      .rd_line(d_line), .rd_word(d_word)
   );
endmodule

// File: tb/dcache_lineops_bench.sv
`timescale 1ns/1ps
module dcache_lineops_bench;
   localparam int LINES = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [1:0]   req_cmd = 2'd0;
   logic [31:0]  req_addr = '0;
   logic [31:0]  req_wdata = '0;
   logic [3:0]   req_be = '0;
   logic         req_priv = 1'b0;
   logic         req_ready, rsp_valid, fault, mem_req, mem_we;
   logic [31:0]  rsp_rdata, mem_addr;
   logic [511:0] mem_wdata;
   logic [511:0] mem_rdata = '0;
   logic         mem_ack = 1'b0;

   dcache_lineops u_dcache_lineops (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_priv(req_priv),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .fault(fault),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   always #4 clk = ~clk;

   int errors = 0;
   int checks = 0;
   bit running = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   // bench memory and reference state
   logic [511:0] bmem [LINES];
   logic [511:0] rmem [LINES];
   logic [511:0] rline [4];
   bit           rvalid [4];
   bit           rdirty [4];
   logic [23:0]  rtag [4];
   int lat_cfg = 1;
   int wait_cnt = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;

   function automatic logic [31:0] pat(int l, int w);
      return {8'(l), 8'(w), 8'h5A, 8'(l * 3 + w)};
   endfunction

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (rst_n && mem_req) begin
         if (wait_cnt >= lat_cfg) begin
            wait_cnt = 0;
            mem_ack = 1'b1;
            if (mem_we) begin
               bmem[mem_addr[11:6]] = mem_wdata;
               wr_cnt++;
            end else begin
               mem_rdata = bmem[mem_addr[11:6]];
               rd_cnt++;
            end
         end else begin
            wait_cnt++;
         end
      end
   end

   // every-clock protocol comparison
   always @(negedge clk) begin
      if (running) begin
         chk(!(mem_req && req_ready), "R10", "ready while memory busy", {31'd0, req_ready}, 32'd0);
         if (mem_req) chk(mem_addr[5:0] == 6'd0, "R11", "line-aligned memory address", mem_addr, {mem_addr[31:6], 6'd0});
      end
   end

   task automatic model_op(input logic [1:0] cmd, input logic [31:0] a, input logic [31:0] wd,
                           input logic [3:0] be, input bit pv, output bit ef,
                           output logic [31:0] ed, output bit efast, output int erd, output int ewr);
      int idx, wsel, vl;
      logic [23:0] tg;
      bit hit;
      idx = int'(a[7:6]); wsel = int'(a[5:2]); tg = a[31:8];
      ef = 0; ed = '0; efast = 1; erd = 0; ewr = 0;
      hit = rvalid[idx] && (rtag[idx] == tg);
      if (cmd >= 2 && !pv) begin
         ef = 1;
         return;
      end
      case (cmd)
         2'd0, 2'd1: begin
            if (!hit) begin
               efast = 0;
               if (rvalid[idx] && rdirty[idx]) begin
                  vl = int'(rtag[idx][3:0]) * 4 + idx;
                  rmem[vl] = rline[idx];
                  ewr = 1;
               end
               rline[idx] = rmem[a[11:6]];
               erd = 1;
               rvalid[idx] = 1; rdirty[idx] = 0; rtag[idx] = tg;
            end
            if (cmd == 2'd0) begin
               ed = rline[idx][wsel*32 +: 32];
            end else begin
               for (int b = 0; b < 4; b++)
                  if (be[b]) rline[idx][wsel*32 + b*8 +: 8] = wd[b*8 +: 8];
               rdirty[idx] = 1;
            end
         end
         2'd2: begin
            if (!hit && rvalid[idx] && rdirty[idx]) begin
               vl = int'(rtag[idx][3:0]) * 4 + idx;
               rmem[vl] = rline[idx];
               ewr = 1;
               efast = 0;
            end
            rline[idx] = '0;
            rvalid[idx] = 1; rdirty[idx] = 1; rtag[idx] = tg;
         end
         default: begin
            if (hit) begin
               rvalid[idx] = 0; rdirty[idx] = 0;
            end
         end
      endcase
   endtask

   task automatic do_op(input logic [1:0] cmd, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input bit pv, input string rq_in);
      bit ef, efast;
      logic [31:0] ed;
      int erd, ewr, rd0, wr0, cyc;
      string rq;
      model_op(cmd, a, wd, be, pv, ef, ed, efast, erd, ewr);
      rq = ef ? "R9" : rq_in;
      rd0 = rd_cnt; wr0 = wr_cnt;
      chk(req_ready === 1'b1, "R10", "idle before request", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1; req_cmd = cmd; req_addr = a; req_wdata = wd; req_be = be; req_priv = pv;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0;
      while (rsp_valid !== 1'b1 && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
      chk(rsp_valid === 1'b1, rq, "response", {31'd0, rsp_valid}, 32'd1);
      chk(fault === ef, rq, "fault", {31'd0, fault}, {31'd0, ef});
      if (cmd == 2'd0 && !ef) chk(rsp_rdata === ed, rq, "load data", rsp_rdata, ed);
      if (efast) chk(cyc == 0, rq, "cycles to response", cyc, 0);
      chk(rd_cnt - rd0 == erd, rq, "memory reads", rd_cnt - rd0, erd);
      chk(wr_cnt - wr0 == ewr, rq, "memory write-backs", wr_cnt - wr0, ewr);
      if (ef) begin
         @(negedge clk);
         chk(fault === 1'b0, "R9", "fault pulse width", {31'd0, fault}, 32'd0);
      end
   endtask

   initial begin
      for (int l = 0; l < LINES; l++)
         for (int w = 0; w < 16; w++) begin
            bmem[l][w*32 +: 32] = pat(l, w);
            rmem[l][w*32 +: 32] = pat(l, w);
         end
      for (int s = 0; s < 4; s++) begin
         rvalid[s] = 0; rdirty[s] = 0; rtag[s] = '0; rline[s] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(req_ready === 1'b1 && rsp_valid === 1'b0 && fault === 1'b0 && mem_req === 1'b0,
          "R10", "reset outputs", {28'd0, req_ready, rsp_valid, fault, mem_req}, 32'h8);
      rst_n = 1'b1;
      @(negedge clk);
      running = 1;

      do_op(2'd0, 32'h000, '0, 4'h0, 0, "R3");            // clean miss: read only
      do_op(2'd0, 32'h008, '0, 4'h0, 0, "R1");            // hit in next cycle
      do_op(2'd1, 32'h008, 32'hDEADBEEF, 4'b0101, 0, "R2");
      do_op(2'd0, 32'h008, '0, 4'h0, 0, "R2");            // merged bytes
      do_op(2'd0, 32'h100, '0, 4'h0, 1, "R3");            // dirty victim: write then read
      chk(bmem[0][2*32 +: 32] === {pat(0,2)[31:24], 8'hAD, pat(0,2)[15:8], 8'hEF},
          "R2", "merged word in memory", bmem[0][2*32 +: 32], {pat(0,2)[31:24], 8'hAD, pat(0,2)[15:8], 8'hEF});
      do_op(2'd2, 32'h040, '0, 4'h0, 1, "R4");            // zero into empty set
      do_op(2'd0, 32'h07C, '0, 4'h0, 0, "R4");            // reads zero, no fetch
      do_op(2'd2, 32'h140, '0, 4'h0, 1, "R5");            // evicts zeroed dirty line
      chk(bmem[1] === '0, "R6", "zeros written back", bmem[1][31:0], 32'd0);
      do_op(2'd2, 32'h080, '0, 4'h0, 0, "R9");            // refused
      do_op(2'd0, 32'h080, '0, 4'h0, 0, "R9");            // nothing installed: misses
      do_op(2'd3, 32'h140, '0, 4'h0, 0, "R9");            // refused discard
      do_op(2'd0, 32'h140, '0, 4'h0, 0, "R9");            // still resident
      do_op(2'd1, 32'h0C0, 32'h12345678, 4'hF, 0, "R3");
      do_op(2'd3, 32'h0C0, '0, 4'h0, 1, "R7");            // dirty discard, no write
      do_op(2'd0, 32'h0C0, '0, 4'h0, 0, "R7");
      chk(rsp_rdata === pat(3, 0), "R7", "old memory word after discard", rsp_rdata, pat(3, 0));
      do_op(2'd3, 32'h200, '0, 4'h0, 1, "R8");            // discard miss

      for (int i = 0; i < 400; i++) begin
         logic [1:0] c;
         logic [31:0] a;
         string rq;
         lat_cfg = $urandom_range(0, 3);
         c = 2'($urandom_range(0, 3));
         a = {20'd0, 10'($urandom), 2'b00};
         rq = (c == 2'd0) ? "R1" : (c == 2'd1) ? "R2" : (c == 2'd2) ? "R4" : "R7";
         do_op(c, a, $urandom, 4'($urandom), ($urandom_range(0, 4) != 0), rq);
      end

      begin
         bit same = 1;
         for (int l = 0; l < LINES; l++) if (bmem[l] !== rmem[l]) same = 0;
         chk(same, "R6", "final memory image", {31'd0, same}, 32'd1);
      end
      running = 0;
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule